// File: doc/BRIEF.md
# Word-Level Triple Voter

This block takes three W-bit words from three replicated producers and returns a single voted word, plus two flags. The vote is taken on complete words through equality comparators and a word-wide multiplexer, never one bit at a time. The result is therefore always one of the three words that came in, and never a mix of their bits that no producer generated.

In the default compare-and-select mode, the first two inputs are compared. If they match, the first input is passed on. If they differ, the third input is passed on. So whenever any two inputs agree, the output carries the agreeing value. A second mode treats the three words as unsigned integers and passes on the middle one. Both modes drive the same two flags. One flag reports that the first two inputs differ. The other reports that no two inputs agree at all.

The output can be registered by parameter. When it is, the word and both flags come out together one clock after the inputs. The asynchronous active-low reset is released synchronously inside the block.

Top module: `word_voter3`

## Requirements
- R1: The voted output word always equals `in_a`, `in_b` or `in_c` (as seen through the output stage), in both modes.
- R2: In compare mode (`med_sel`=0), when `in_a` equals `in_b`, the output equals `in_a`.
- R3: In compare mode, when `in_a` differs from `in_b`, the output equals `in_c`. If `in_c` equals `in_a` or `in_b`, this makes the output the majority value.
- R4: `disagree` is 1 exactly when `in_a` differs from `in_b`, in either mode.
- R5: `no_majority` is 1 exactly when all three inputs are pairwise different, in either mode. `no_majority`=1 implies `disagree`=1.
- R6: In median mode (`med_sel`=1), the output is the middle value of the three inputs read as unsigned integers. When two or three inputs are equal, that repeated value is output.
- R7: With REGISTER_OUT=1, the word and both flags appear one rising clock edge after the inputs are sampled, all in the same cycle.
- R8: While `rst_n` is low, all outputs are 0. After `rst_n` rises, the output register stays cleared through two more rising edges before it starts loading.
- R9: Bit-mixed inputs 000, 101 and 110 (low three bits, upper bits zero) give 110 in compare mode and 101 in median mode. A bitwise majority of these inputs would give 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_a | input | W | Word from first replica |
| in_b | input | W | Word from second replica |
| in_c | input | W | Word from third replica |
| med_sel | input | 1 | 0 = compare-and-select, 1 = unsigned median |
| vote_out | output | W | Voted word |
| disagree | output | 1 | First and second inputs differ |
| no_majority | output | 1 | All three inputs pairwise different |

## Verification
The voter is driven with every agreement shape in both modes: all three equal, each of the three possible pairs agreeing against a lone outlier, and all three distinct. These patterns separate a comparator that picks the wrong pair, a selector that picks the wrong input, and flags that confuse "first two differ" with "no majority". The bit-mixed triple and median cases with ties, extremes and unsorted orderings separate word voting from bitwise voting, and a true median from a minimum or maximum. A long run of random words with frequently forced matches checks output latency and flag alignment every cycle against a behavioural model.

// File: rtl/voter_pkg.sv
package voter_pkg;
  typedef enum logic {
    VM_COMPARE = 1'b0,
    VM_MEDIAN  = 1'b1
  } vote_mode_e;

  typedef struct packed {
    logic ab_eq;
    logic bc_eq;
    logic ac_eq;
  } eq_flags_t;
endpackage

// File: rtl/vote_rst_sync.sv
module vote_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/vote_eq_bank.sv
module vote_eq_bank
  import voter_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] word_a,
  input  logic [W-1:0] word_b,
  input  logic [W-1:0] word_c,
  output eq_flags_t    eq
);
  always_comb begin
    eq.ab_eq = (word_a == word_b);
    eq.bc_eq = (word_b == word_c);
    eq.ac_eq = (word_a == word_c);
  end
endmodule

// File: rtl/vote_median.sv
module vote_median #(
  parameter int W = 8
) (
  input  logic [W-1:0] word_a,
  input  logic [W-1:0] word_b,
  input  logic [W-1:0] word_c,
  output logic [W-1:0] mid_word
);
  logic a_le_b, b_le_c, a_le_c;
  logic a_mid, b_mid;

  always_comb begin
    a_le_b = (word_a <= word_b);
    b_le_c = (word_b <= word_c);
    a_le_c = (word_a <= word_c);
    a_mid  = (a_le_b && !a_le_c) || (!a_le_b && a_le_c)
             || (word_a == word_b) || (word_a == word_c);
    b_mid  = (a_le_b && b_le_c) || (!a_le_b && !b_le_c);
    if (a_mid)      mid_word = word_a;
    else if (b_mid) mid_word = word_b;
    else            mid_word = word_c;
  end
endmodule

// File: rtl/vote_core.sv
module vote_core
  import voter_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] word_a,
  input  logic [W-1:0] word_b,
  input  logic [W-1:0] word_c,
  input  vote_mode_e   mode,
  output logic [W-1:0] sel_word,
  output logic         sel_disagree,
  output logic         sel_nomaj
);
  eq_flags_t    eq;
  logic [W-1:0] cmp_word;
  logic [W-1:0] med_word;

  vote_eq_bank #(.W(W)) u_eq (
    .word_a(word_a), .word_b(word_b), .word_c(word_c), .eq(eq)
  );

  vote_median #(.W(W)) u_med (
    .word_a(word_a), .word_b(word_b), .word_c(word_c), .mid_word(med_word)
  );

  always_comb begin
    cmp_word     = eq.ab_eq ? word_a : word_c;
    sel_word     = (mode == VM_MEDIAN) ? med_word : cmp_word;
    sel_disagree = !eq.ab_eq;
    sel_nomaj    = !eq.ab_eq && !eq.bc_eq && !eq.ac_eq;
  end
endmodule

// File: rtl/vote_out_stage.sv
module vote_out_stage #(
  parameter int W            = 8,
  parameter bit REGISTER_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n_sync,
  input  logic [W-1:0] word_d,
  input  logic         dis_d,
  input  logic         nomaj_d,
  output logic [W-1:0] word_q,
  output logic         dis_q,
  output logic         nomaj_q
);
  localparam int PW = W + 2;

  logic [PW-1:0] pack_d;
  assign pack_d = {nomaj_d, dis_d, word_d};

  generate
    if (REGISTER_OUT) begin : g_reg
      logic [PW-1:0] pack_q;
      logic          load_en;
      assign load_en = 1'b1;
      always_ff @(posedge clk or negedge rst_n_sync) begin
        if (!rst_n_sync)  pack_q <= '0;
        else if (load_en) pack_q <= pack_d;
      end
      assign {nomaj_q, dis_q, word_q} = pack_q;
    end else begin : g_pass
      assign {nomaj_q, dis_q, word_q} = pack_d;
    end
  endgenerate
endmodule

// File: rtl/word_voter3.sv
module word_voter3
  import voter_pkg::*;
#(
  parameter int W            = 8,
  parameter bit REGISTER_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  input  logic         med_sel,
  output logic [W-1:0] vote_out,
  output logic         disagree,
  output logic         no_majority
);
  logic         rst_n_sync;
  logic [W-1:0] sel_word;
  logic         sel_dis, sel_nomaj;
  vote_mode_e   mode;

  assign mode = vote_mode_e'(med_sel);

  vote_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  vote_core #(.W(W)) u_core (
    .word_a(in_a), .word_b(in_b), .word_c(in_c), .mode(mode),
    .sel_word(sel_word), .sel_disagree(sel_dis), .sel_nomaj(sel_nomaj)
  );

  vote_out_stage #(.W(W), .REGISTER_OUT(REGISTER_OUT)) u_out (
    .clk(clk), .rst_n_sync(rst_n_sync),
    .word_d(sel_word), .dis_d(sel_dis), .nomaj_d(sel_nomaj),
    .word_q(vote_out), .dis_q(disagree), .nomaj_q(no_majority)
  );

  assert_word_is_input_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_word == in_a) || (sel_word == in_b) || (sel_word == in_c));

  assert_pair_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!med_sel && in_a == in_b) |-> (sel_word == in_a));

  assert_third_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!med_sel && in_a != in_b) |-> (sel_word == in_c));

  assert_nomaj_implies_dis_R5: assert property (@(posedge clk) disable iff (!rst_n)
    no_majority |-> disagree);

  assert_median_bounds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    med_sel |-> ((((sel_word >= in_a) ? 1 : 0) + ((sel_word >= in_b) ? 1 : 0)
                 + ((sel_word >= in_c) ? 1 : 0)) >= 2 &&
                 (((sel_word <= in_a) ? 1 : 0) + ((sel_word <= in_b) ? 1 : 0)
                 + ((sel_word <= in_c) ? 1 : 0)) >= 2));

  assert_reset_clear_R8: assert property (@(posedge clk)
    !rst_n_sync |-> (vote_out == '0 || !REGISTER_OUT));
endmodule

// File: tb/tb_word_voter3.sv
module tb_word_voter3;
  localparam int  W      = 8;
  localparam time CLK_NS = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] in_a, in_b, in_c;
  logic         med_sel;
  logic [W-1:0] vote_out;
  logic         disagree, no_majority;

  int n_cmp = 0;
  int n_bad = 0;
  bit armed = 0;
  logic [W-1:0] exp_w;
  logic         exp_d, exp_n;
  string        exp_tag;

  always #(CLK_NS/2) clk = ~clk;

  word_voter3 #(.W(W), .REGISTER_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .med_sel(med_sel), .vote_out(vote_out), .disagree(disagree),
    .no_majority(no_majority)
  );

  function automatic logic [W-1:0] model_word(int a, int b, int c, bit m);
    int v[$];
    if (m) begin
      v = '{a, b, c};
      v.sort();
      return v[1][W-1:0];
    end
    if (a == b) return a[W-1:0];
    return c[W-1:0];
  endfunction

  task automatic check(string tag, logic [W-1:0] aw, logic ad, logic an,
                       logic [W-1:0] ew, logic ed, logic en);
    n_cmp++;
    if (aw !== ew || ad !== ed || an !== en) begin
      n_bad++;
      $display("FAIL %s: got word=%0h dis=%0b nomaj=%0b, expected word=%0h dis=%0b nomaj=%0b",
               tag, aw, ad, an, ew, ed, en);
    end
  endtask

  // Drive at negedge; first compare against inputs applied one cycle earlier (R7)
  task automatic apply(int a, int b, int c, bit m, string tag);
    @(negedge clk);
    if (armed) check({exp_tag, " R7"}, vote_out, disagree, no_majority, exp_w, exp_d, exp_n);
    in_a = a[W-1:0]; in_b = b[W-1:0]; in_c = c[W-1:0]; med_sel = m;
    exp_w = model_word(a[W-1:0], b[W-1:0], c[W-1:0], m);
    exp_d = (a[W-1:0] != b[W-1:0]);
    exp_n = exp_d && (b[W-1:0] != c[W-1:0]) && (a[W-1:0] != c[W-1:0]);
    exp_tag = tag;
    armed = 1;
  endtask

  initial begin
    #(CLK_NS * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_a = 8'h5a; in_b = 8'h33; in_c = 8'hc1; med_sel = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 reset", vote_out, disagree, no_majority, '0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 sync hold 1", vote_out, disagree, no_majority, '0, 1'b0, 1'b0);
    @(negedge clk);
    check("R8 sync hold 2", vote_out, disagree, no_majority, '0, 1'b0, 1'b0);

    apply(8'h42, 8'h42, 8'h42, 0, "R2 all equal");
    apply(8'h42, 8'h42, 8'h17, 0, "R2 a=b");
    apply(8'h42, 8'h17, 8'h42, 0, "R3 a=c");
    apply(8'h17, 8'h42, 8'h42, 0, "R3 b=c");
    apply(8'h01, 8'h02, 8'h03, 0, "R5 all differ cmp");
    apply(3'b000, 3'b101, 3'b110, 0, "R9 bitmix cmp");
    apply(3'b000, 3'b101, 3'b110, 1, "R9 bitmix med");
    apply(8'h90, 8'h10, 8'h50, 1, "R6 median unsorted");
    apply(8'h10, 8'h90, 8'h50, 1, "R6 median unsorted2");
    apply(8'h00, 8'hff, 8'h80, 1, "R6 median extremes");
    apply(8'h20, 8'h20, 8'hf0, 1, "R6 median tie ab");
    apply(8'hf0, 8'h20, 8'hf0, 1, "R6 median tie ac");
    apply(8'h05, 8'h77, 8'h77, 1, "R6 median tie bc");
    apply(8'h33, 8'h44, 8'h55, 1, "R5 all differ med");
    apply(8'hff, 8'hff, 8'hff, 1, "R4 med equal");
    for (int i = 0; i < 2000; i++) begin
      int a, b, c;
      a = $urandom_range(0, 255); b = $urandom_range(0, 255); c = $urandom_range(0, 255);
      case ($urandom_range(0, 4))
        0: b = a;
        1: c = a;
        2: c = b;
        default: ;
      endcase
      apply(a, b, c, bit'($urandom_range(0, 1)), "R1 R4 random");
    end
    @(negedge clk);
    check({exp_tag, " R7"}, vote_out, disagree, no_majority, exp_w, exp_d, exp_n);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule